// File: doc/BRIEF.md
# Prioritized Interrupt Controller with Acknowledge Handshake

This block gathers a wide set of level-sensitive interrupt requests and drives a single interrupt line to a processor. Each request can be blocked by its own mask bit, and each has a small priority value held in a register of its own. When no winner is held, the controller picks the best unmasked pending request and stores its number. It then asserts the interrupt line.

The stored number stays frozen, and no new arbitration takes place, until software writes an agreement command to the control register. That write releases the line for at least one cycle. The controller then arbitrates again over whatever is pending at that point. If the held source goes away before software reads it, the number stays as it was, so a handler can spot the spurious case by checking the source's enable.

Software reaches every register through a plain 32-bit read/write bus that decodes a 4 KB window. Reads are combinational in the same cycle as the request. Writes take effect at the next rising clock edge.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset every mask bit is 1, every priority value is 0, the stored number is 0, the config and idle registers read 0, and `irq_o` is low.
- R2: The mask word at offset 0x080+4*k covers inputs 32*k to 32*k+31, with input n at bit (n mod 32) of word n/32. A bit of 1 stops that input from ever winning, and a bit of 0 lets it compete.
- R3: Each mask word reads back exactly the 32-bit value last written to it.
- R4: Input n owns the priority word at offset 0x100+4*n (0x100 to 0x2FC for 128 inputs). Only bits [5:0] are stored, and bits [31:6] read as 0.
- R5: Among unmasked pending inputs, the lowest priority value wins, and 0 is a valid value. On equal values the lower input number wins.
- R6: The word at offset 0x040 returns the stored winner number in bits [6:0], and bits [31:7] read as 0. Writes to it are ignored.
- R7: While no winner is held and some unmasked input is pending, the next rising edge stores the winner, and `irq_o` is high from that edge on.
- R8: While a winner is held, the stored number and `irq_o` do not change until the agreement write. This holds even if the source drops, is masked, or is outranked.
- R9: A write to offset 0x048 with bit 0 set, made while a winner is held, takes `irq_o` low at the next edge. The line stays low for that whole cycle, and arbitration resumes at the edge after. A write there with bit 0 clear has no effect.
- R10: Offset 0x048 always reads as 0.
- R11: Offset 0x010 stores a 1-bit auto-idle flag in bit 0 and offset 0x050 stores a 2-bit idle field in bits [1:0], both readable and writable. Any other offset reads 0 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | 128 | Level-sensitive interrupt requests |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 12 | Byte address inside the 4 KB window |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid in the cycle of a read request; 0 otherwise |
| irq_o | output | 1 | Interrupt line to the processor |

## Verification
The bench builds the block with its defaults: 128 inputs and 6-bit priorities. This gives four mask words, so the bank seams at inputs 31/32 and the top input 127 at offset 0x2FC can be reached, along with the extremes 0 and 63 of the priority range. Directed phases cover frozen winners, spurious drops, outranking and tie-breaks. A long random phase then mixes mask, priority and agreement writes with changing requests, checked against a scan-based model.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned ADDR_W = 12;
  localparam int unsigned DATA_W = 32;

  localparam logic [ADDR_W-1:0] OFF_SYSCFG = 12'h010;
  localparam logic [ADDR_W-1:0] OFF_ACTIVE = 12'h040;
  localparam logic [ADDR_W-1:0] OFF_CTRL   = 12'h048;
  localparam logic [ADDR_W-1:0] OFF_IDLE   = 12'h050;
  localparam logic [ADDR_W-1:0] OFF_MASK   = 12'h080;
  localparam logic [ADDR_W-1:0] OFF_LVL    = 12'h100;
endpackage

// File: rtl/irq_regs.sv
module irq_regs
  import irq_pkg::*;
#(
  parameter int N_SRC  = 128,
  parameter int PRIO_W = 6,
  parameter int ID_W   = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ID_W-1:0]   act_id_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [N_SRC-1:0]  mask_o,
  output logic [PRIO_W-1:0] lvl_o [N_SRC],
  output logic              ack_o
);
  localparam int N_BANK = (N_SRC + 31) / 32;
  localparam int BANK_W = (N_BANK > 1) ? $clog2(N_BANK) : 1;

  logic              wr, rd;
  logic [ADDR_W-1:0] mask_off, lvl_off;
  logic              mask_hit, lvl_hit;
  logic [BANK_W-1:0] bank;
  logic [ID_W-1:0]   lvl_idx;
  logic [31:0]       mask_q [N_BANK];
  logic              sys_q;
  logic [1:0]        idle_q;

  assign wr       = req_i & we_i;
  assign rd       = req_i & ~we_i;
  assign mask_off = addr_i - OFF_MASK;
  assign lvl_off  = addr_i - OFF_LVL;
  assign mask_hit = (addr_i >= OFF_MASK) && (int'(mask_off[ADDR_W-1:2]) < N_BANK);
  assign lvl_hit  = (addr_i >= OFF_LVL) && (int'(lvl_off[ADDR_W-1:2]) < N_SRC);
  assign bank     = mask_off[BANK_W+1:2];
  assign lvl_idx  = lvl_off[ID_W+1:2];
  assign ack_o    = wr && (addr_i == OFF_CTRL) && wdata_i[0];

  for (genvar b = 0; b < N_BANK; b++) begin : g_bank
    logic [31:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= '1;
      else if (wr && mask_hit && bank == BANK_W'(b)) q <= wdata_i;
    end
    assign mask_q[b] = q;
  end

  for (genvar n = 0; n < N_SRC; n++) begin : g_src
    localparam int B = n / 32;
    localparam int S = n % 32;
    logic [PRIO_W-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= '0;
      else if (wr && lvl_hit && lvl_idx == ID_W'(n)) q <= wdata_i[PRIO_W-1:0];
    end
    assign lvl_o[n]  = q;
    assign mask_o[n] = mask_q[B][S];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sys_q  <= 1'b0;
      idle_q <= 2'b00;
    end else if (wr) begin
      if (addr_i == OFF_SYSCFG) sys_q  <= wdata_i[0];
      if (addr_i == OFF_IDLE)   idle_q <= wdata_i[1:0];
    end
  end

  always_comb begin
    rdata_o = '0;
    if (rd) begin
      if (mask_hit)     rdata_o = mask_q[bank];
      else if (lvl_hit) rdata_o = DATA_W'(lvl_o[lvl_idx]);
      else begin
        case (addr_i)
          OFF_SYSCFG: rdata_o = {31'b0, sys_q};
          OFF_IDLE:   rdata_o = {30'b0, idle_q};
          OFF_ACTIVE: rdata_o = DATA_W'(act_id_i);
          default:    rdata_o = '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/irq_arb_tree.sv
module irq_arb_tree #(
  parameter int N_SRC  = 128,
  parameter int PRIO_W = 6,
  parameter int ID_W   = 7
) (
  input  logic [N_SRC-1:0]  cand_i,
  input  logic [PRIO_W-1:0] lvl_i [N_SRC],
  output logic              win_v_o,
  output logic [ID_W-1:0]   win_id_o
);
  localparam int LEAVES = 2 ** ID_W;
  localparam int NODES  = 2 * LEAVES - 1;

  logic              node_v  [NODES];
  logic [PRIO_W-1:0] node_p  [NODES];
  logic [ID_W-1:0]   node_id [NODES];

  for (genvar j = 0; j < LEAVES; j++) begin : g_leaf
    if (j < N_SRC) begin : g_real
      assign node_v[LEAVES-1+j]  = cand_i[j];
      assign node_p[LEAVES-1+j]  = lvl_i[j];
    end else begin : g_pad
      assign node_v[LEAVES-1+j]  = 1'b0;
      assign node_p[LEAVES-1+j]  = '1;
    end
    assign node_id[LEAVES-1+j] = ID_W'(j);
  end

  // heap order: left subtree always holds the lower numbers, so ties go left
  for (genvar i = 0; i < LEAVES - 1; i++) begin : g_node
    localparam int L = 2 * i + 1;
    localparam int R = 2 * i + 2;
    logic take_l;
    assign take_l     = node_v[L] && (!node_v[R] || node_p[L] <= node_p[R]);
    assign node_v[i]  = node_v[L] | node_v[R];
    assign node_p[i]  = take_l ? node_p[L]  : node_p[R];
    assign node_id[i] = take_l ? node_id[L] : node_id[R];
  end

  assign win_v_o  = node_v[0];
  assign win_id_o = node_id[0];
endmodule

// File: rtl/irq_hold.sv
module irq_hold #(
  parameter int ID_W = 7
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            win_v_i,
  input  logic [ID_W-1:0] win_id_i,
  input  logic            ack_i,
  output logic            irq_o,
  output logic [ID_W-1:0] act_id_o
);
  logic hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q   <= 1'b0;
      act_id_o <= '0;
    end else if (hold_q) begin
      if (ack_i) hold_q <= 1'b0;
    end else if (win_v_i) begin
      hold_q   <= 1'b1;
      act_id_o <= win_id_i;
    end
  end

  assign irq_o = hold_q;
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import irq_pkg::*;
#(
  parameter int N_SRC  = 128,
  parameter int PRIO_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_SRC-1:0]  src_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  localparam int ID_W = (N_SRC > 1) ? $clog2(N_SRC) : 1;

  logic [N_SRC-1:0]  mask_w;
  logic [PRIO_W-1:0] lvl_w [N_SRC];
  logic              ack_w, win_v;
  logic [ID_W-1:0]   win_id, act_id;

  irq_regs #(.N_SRC(N_SRC), .PRIO_W(PRIO_W), .ID_W(ID_W)) u_regs (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i,
    .act_id_i (act_id),
    .rdata_o,
    .mask_o   (mask_w),
    .lvl_o    (lvl_w),
    .ack_o    (ack_w)
  );

  irq_arb_tree #(.N_SRC(N_SRC), .PRIO_W(PRIO_W), .ID_W(ID_W)) u_arb (
    .cand_i   (src_i & ~mask_w),
    .lvl_i    (lvl_w),
    .win_v_o  (win_v),
    .win_id_o (win_id)
  );

  irq_hold #(.ID_W(ID_W)) u_hold (
    .clk_i, .rst_ni,
    .win_v_i  (win_v),
    .win_id_i (win_id),
    .ack_i    (ack_w),
    .irq_o,
    .act_id_o (act_id)
  );
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk
  import irq_pkg::*;
#(
  parameter int N_SRC = 128,
  parameter int ID_W  = 7
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [N_SRC-1:0]  src_i,
  input logic [N_SRC-1:0]  mask_i,
  input logic [ID_W-1:0]   act_i,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              irq_o
);
  logic             ack;
  logic [N_SRC-1:0] cand_d;

  assign ack = req_i && we_i && (addr_i == OFF_CTRL) && wdata_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cand_d <= '0;
    else         cand_d <= src_i & ~mask_i;
  end

  // R8
  hold_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o && !ack |=> irq_o && $stable(act_i));

  // R9
  ack_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o && ack |=> !irq_o);

  // R7
  rise_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> cand_d[act_i]);

  // R7
  idle_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_o && (|(src_i & ~mask_i)) |=> irq_o);

  // R10
  ctrl_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && !we_i && addr_i == OFF_CTRL |-> rdata_o == '0);

  // R6
  act_field_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && !we_i && addr_i == OFF_ACTIVE |-> rdata_o[DATA_W-1:ID_W] == '0);
endmodule

bind prio_irq_ctrl irq_ctrl_chk #(.N_SRC(N_SRC), .ID_W(ID_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .src_i   (src_i),
  .mask_i  (mask_w),
  .act_i   (act_id),
  .req_i   (req_i),
  .we_i    (we_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .rdata_o (rdata_o),
  .irq_o   (irq_o)
);

// File: tb/sim_prio_irq_ctrl.sv
module sim_prio_irq_ctrl;
  localparam int CLK_PERIOD = 10;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic [127:0] src_i = '0;
  logic         req_i = 1'b0;
  logic         we_i = 1'b0;
  logic [11:0]  addr_i = '0;
  logic [31:0]  wdata_i = '0;
  logic [31:0]  rdata_o;
  logic         irq_o;

  int    n_cmp = 0;
  int    n_bad = 0;
  bit    done = 1'b0;
  string cur_req = "R1";

  prio_irq_ctrl u0 (.clk_i, .rst_ni, .src_i, .req_i, .we_i, .addr_i, .wdata_i, .rdata_o, .irq_o);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  // ---------------- reference model ----------------
  bit [31:0] m_mask [4];
  int        m_lvl  [128];
  bit        m_sys;
  bit [1:0]  m_idle;
  bit        m_hold;
  int        m_act;

  function automatic int m_best();
    int best = -1;
    int bp = 1000;
    for (int n = 0; n < 128; n++) begin
      if (src_i[n] && !m_mask[n/32][n%32] && m_lvl[n] < bp) begin
        best = n;
        bp = m_lvl[n];
      end
    end
    return best;
  endfunction

  function automatic bit [31:0] m_read(input int a);
    if (a >= 'h080 && a < 'h090) return m_mask[(a - 'h080) >> 2];
    if (a >= 'h100 && a < 'h300) return 32'(m_lvl[(a - 'h100) >> 2]);
    if (a == 'h010) return {31'b0, m_sys};
    if (a == 'h050) return {30'b0, m_idle};
    if (a == 'h040) return 32'(m_act);
    return 32'h0;
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < 4; k++) m_mask[k] = '1;
      for (int n = 0; n < 128; n++) m_lvl[n] = 0;
      m_sys = 0; m_idle = 0; m_hold = 0; m_act = 0;
    end else begin
      int b;
      int a;
      b = m_best();
      a = int'(addr_i);
      if (m_hold) begin
        if (req_i && we_i && a == 'h048 && wdata_i[0]) m_hold = 0;
      end else if (b >= 0) begin
        m_hold = 1;
        m_act = b;
      end
      if (req_i && we_i) begin
        if (a >= 'h080 && a < 'h090) m_mask[(a - 'h080) >> 2] = wdata_i;
        else if (a >= 'h100 && a < 'h300) m_lvl[(a - 'h100) >> 2] = int'(wdata_i[5:0]);
        else if (a == 'h010) m_sys = wdata_i[0];
        else if (a == 'h050) m_idle = wdata_i[1:0];
      end
    end
  end

  // compare every cycle, away from the rising edge
  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      bit [31:0] er;
      er = (req_i && !we_i) ? m_read(int'(addr_i)) : 32'h0;
      n_cmp += 2;
      if (irq_o !== m_hold) begin
        n_bad++;
        $display("FAIL %s irq_o actual %0b expected %0b", cur_req, irq_o, m_hold);
      end
      if (rdata_o !== er) begin
        n_bad++;
        $display("FAIL %s rdata_o @%h actual %h expected %h", cur_req, addr_i, rdata_o, er);
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk_i); #1;
    req_i = 1; we_i = 1; addr_i = a; wdata_i = d;
    @(negedge clk_i); #1;
    req_i = 0; we_i = 0;
  endtask

  // read with a literal expectation taken from the requirement
  task automatic rd_chk(input logic [11:0] a, input logic [31:0] exp);
    @(negedge clk_i); #1;
    req_i = 1; we_i = 0; addr_i = a;
    @(negedge clk_i);
    n_cmp++;
    if (rdata_o !== exp) begin
      n_bad++;
      $display("FAIL %s read @%h actual %h expected %h", cur_req, a, rdata_o, exp);
    end
    #1 req_i = 0;
  endtask

  task automatic irq_chk(input logic exp);
    @(negedge clk_i);
    n_cmp++;
    if (irq_o !== exp) begin
      n_bad++;
      $display("FAIL %s irq_o actual %0b expected %0b", cur_req, irq_o, exp);
    end
  endtask

  task automatic set_src(input logic [127:0] v);
    @(negedge clk_i); #1;
    src_i = v;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: run did not complete, actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    #1 rst_ni = 1;

    cur_req = "R1";
    irq_chk(1'b0);
    for (int k = 0; k < 4; k++) rd_chk(12'(12'h080 + 4 * k), 32'hFFFF_FFFF);
    rd_chk(12'h100, 32'h0);
    rd_chk(12'h2FC, 32'h0);
    rd_chk(12'h010, 32'h0);
    rd_chk(12'h050, 32'h0);
    rd_chk(12'h040, 32'h0);

    cur_req = "R10";
    rd_chk(12'h048, 32'h0);

    cur_req = "R3";
    wr(12'h084, 32'hA5A5_0F0F);
    rd_chk(12'h084, 32'hA5A5_0F0F);
    rd_chk(12'h080, 32'hFFFF_FFFF);
    wr(12'h084, 32'hFFFF_FFFF);

    cur_req = "R11";
    wr(12'h010, 32'hFFFF_FFFF);
    rd_chk(12'h010, 32'h1);
    wr(12'h050, 32'h7);
    rd_chk(12'h050, 32'h3);
    wr(12'h050, 32'h0);
    rd_chk(12'h050, 32'h0);
    wr(12'h3F0, 32'hDEAD_BEEF);
    rd_chk(12'h3F0, 32'h0);

    cur_req = "R4";
    wr(12'h114, 32'hFFFF_FF2A);
    rd_chk(12'h114, 32'h0000_002A);
    wr(12'h2FC, 32'h3F);
    rd_chk(12'h2FC, 32'h3F);
    wr(12'h2FC, 32'h0);
    wr(12'h114, 32'h0);

    // R2: only input 40 (bank 1, bit 8) unmasked; 41 stays blocked
    cur_req = "R2";
    wr(12'h084, ~(32'h1 << 8));
    set_src(128'h1 << 41);
    idle(3);
    irq_chk(1'b0);
    cur_req = "R7";
    set_src((128'h1 << 41) | (128'h1 << 40));
    irq_chk(1'b1);
    cur_req = "R6";
    rd_chk(12'h040, 32'd40);
    wr(12'h040, 32'h7F);
    rd_chk(12'h040, 32'd40);

    cur_req = "R9";
    wr(12'h048, 32'h0);
    irq_chk(1'b1);
    @(negedge clk_i); #1;
    req_i = 1; we_i = 1; addr_i = 12'h048; wdata_i = 32'h1;
    @(negedge clk_i);
    n_cmp++;
    if (irq_o !== 1'b0) begin
      n_bad++;
      $display("FAIL R9 irq_o after agreement actual %0b expected 0", irq_o);
    end
    #1 req_i = 0; we_i = 0;
    irq_chk(1'b1);
    set_src('0);
    wr(12'h048, 32'h1);
    idle(2);
    irq_chk(1'b0);

    // R8: 5 latched, then outranked by 100, then 5 drops
    cur_req = "R8";
    wr(12'h080, ~(32'h1 << 5));
    wr(12'h08C, ~(32'h1 << 4) & ~(32'h1 << 31));
    wr(12'h114, 32'd10);
    wr(12'h290, 32'd3);
    set_src(128'h1 << 5);
    idle(1);
    rd_chk(12'h040, 32'd5);
    set_src((128'h1 << 5) | (128'h1 << 100));
    idle(2);
    rd_chk(12'h040, 32'd5);
    set_src(128'h1 << 100);
    wr(12'h080, 32'hFFFF_FFFF);
    idle(2);
    rd_chk(12'h040, 32'd5);
    irq_chk(1'b1);
    wr(12'h048, 32'h1);
    idle(1);
    rd_chk(12'h040, 32'd100);

    // R5: tie at level 3 between 5 and 100; then 127 at level 0
    cur_req = "R5";
    wr(12'h080, ~(32'h1 << 5));
    wr(12'h114, 32'd3);
    set_src((128'h1 << 5) | (128'h1 << 100));
    wr(12'h048, 32'h1);
    idle(1);
    rd_chk(12'h040, 32'd5);
    set_src((128'h1 << 5) | (128'h1 << 100) | (128'h1 << 127));
    wr(12'h048, 32'h1);
    idle(1);
    rd_chk(12'h040, 32'd127);
    set_src('0);
    wr(12'h048, 32'h1);
    idle(2);

    cur_req = "R2 R3 R4 R5 R7 R8 R9 R11";
    for (int i = 0; i < 4000; i++) begin
      int op;
      @(negedge clk_i); #1;
      if (i % 5 == 0)
        src_i = {$urandom, $urandom, $urandom, $urandom} & {$urandom, $urandom, $urandom, $urandom}
                & {$urandom, $urandom, $urandom, $urandom};
      op = int'($urandom % 8);
      req_i = 0; we_i = 0;
      case (op)
        0: begin req_i = 1; we_i = 1; addr_i = 12'(12'h080 + 4 * ($urandom % 4));
                 wdata_i = $urandom & $urandom; end
        1: begin req_i = 1; we_i = 1; addr_i = 12'(12'h100 + 4 * ($urandom % 128));
                 wdata_i = $urandom; end
        2, 3: begin req_i = 1; we_i = 1; addr_i = 12'h048; wdata_i = $urandom; end
        4: begin req_i = 1; addr_i = 12'h040; end
        5: begin req_i = 1; addr_i = 12'(4 * ($urandom % 1024)); end
        default: ;
      endcase
    end
    @(negedge clk_i); #1;
    req_i = 0; we_i = 0;
    idle(3);
    finish_run();
  end
endmodule